// File: doc/BRIEF.md
# EPROM Program-and-Verify Sequencer

This block burns an image into a UV-erasable or one-time-programmable byte-wide EPROM. After a start request it raises the core supply selection to its programming level and then enables the high program supply. It then walks the image one address at a time. For every byte that is not already in the erased state, it applies fixed-width chip-enable pulses. After each pulse it reads the cell back in a verify cycle and compares it with the intended byte. A byte that reads back correctly is left at once. A byte that still mismatches after the maximum pulse count stops the run with a failure.

When the last address has been programmed, the whole array is read back twice: first with the core supply selected to its upper check level, then at its lower check level. Any mismatch fails the run. On request, the sequencer can first read the two identifier bytes in high-voltage signature mode and refuse to program a part that does not identify correctly.

The image comes from a simple request/acknowledge port. All microsecond timings are converted into clock cycles from a clock-frequency parameter. Supply generation is external: the block only drives the enable and level-select controls. On completion or failure it removes the program supply first, then returns the core supply to nominal, then raises done.

Top module: `eprom_burn_seq`

## Requirements
- R1: While reset is high and after it is released, dev_ce_n and dev_oe_n are 1, and vpp_en, dev_dout_en, sig_hv_en, img_req, done and fail are 0. vcc_sel is 00, which is the nominal level.
- R2: vcc_sel switches to 01 (programming level) at least SETUP_US microseconds' worth of cycles before vpp_en rises. vpp_en is never 1 while vcc_sel is 00.
- R3: Before every falling edge of dev_ce_n with vpp_en high, dev_addr, dev_dout, dev_dout_en, vpp_en and vcc_sel have been unchanged for at least SETUP_US worth of cycles (2 us by default).
- R4: Each program pulse holds dev_ce_n low for exactly PULSE_US worth of cycles, rounded up (100 us by default). During the pulse dev_oe_n stays 1 and the data bus is driven.
- R5: After each pulse the data bus is released. A verify read then drives dev_oe_n low with dev_ce_n high and compares dev_din with the intended byte. A match moves to the next address with no further pulse, so every verify read follows exactly one pulse.
- R6: A byte that fails verify is pulsed again, with up to MAX_PULSES pulses in total (25 by default). If the verify after the last allowed pulse fails, fail is set and no later address is pulsed.
- R7: An image byte of FFh gets no program pulse at all.
- R8: After the last address, every address is read back with dev_ce_n high and dev_oe_n low. The first pass uses vcc_sel 10 (upper check level) and the second uses vcc_sel 11 (lower check level). The first mismatch sets fail and ends the read-back.
- R9: If id_check_en is high at start, two signature reads are made first. Each has sig_hv_en 1, dev_addr equal to 1<<9 plus the selector in bit 0, vpp_en 0 and vcc_sel 00. The expected bytes are 20h with bit 0 clear, then 8Dh with bit 0 set. A mismatch sets fail before any program pulse.
- R10: At the end of a run, vpp_en falls first. vcc_sel returns to 00 at least SETUP_US worth of cycles later, and only then does done rise. done and fail then hold until the next start.
- R11: img_req stays high with a stable img_addr until img_ack, and the byte on img_data is taken in the acknowledge cycle. One request is made per address for programming and one per address for each read-back pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle or finished |
| id_check_en | input | 1 | Sampled at start; enables the signature check |
| img_req | output | 1 | Image byte request |
| img_addr | output | ADDR_W | Address of the requested image byte |
| img_ack | input | 1 | Image byte valid on img_data |
| img_data | input | 8 | Image byte |
| dev_addr | output | ADDR_W | Device address lines |
| dev_dout | output | 8 | Byte driven onto the device data pins |
| dev_dout_en | output | 1 | Drive enable for dev_dout |
| dev_din | input | 8 | Byte read from the device data pins |
| dev_ce_n | output | 1 | Device chip enable, active low; program strobe |
| dev_oe_n | output | 1 | Device output enable, active low |
| vpp_en | output | 1 | Program supply enable |
| vcc_sel | output | 2 | Core supply level: 00 nominal, 01 program, 10 upper check, 11 lower check |
| sig_hv_en | output | 1 | Applies the signature high voltage to address line 9 |
| done | output | 1 | Run finished, supplies back to rest |
| fail | output | 1 | Run failed |

## Verification
The scoreboard predicts every program pulse as an address/data pair. It does this from an image paired with a device model in which each cell needs a set number of pulses. A mixed image with erased bytes and cells needing one, two or three pulses separates the skip, retry and immediate-advance paths. A cell that never programs shows whether the run stops exactly at the pulse limit and whether later addresses are left untouched. A cell that reads wrong only at the lower check level, and a part with a wrong device identifier, show that the read-back uses both levels in order and that the signature check blocks programming. An all-erased image shows that a run can finish with no pulse at all.

// File: rtl/eprom_burn_pkg.sv
package eprom_burn_pkg;

    typedef enum logic [1:0] {
        VSEL_NOM  = 2'b00,
        VSEL_PROG = 2'b01,
        VSEL_HI   = 2'b10,
        VSEL_LO   = 2'b11
    } vsel_e;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_ID_SET,
        ST_ID_RD,
        ST_VCC_UP,
        ST_VPP_UP,
        ST_FETCH,
        ST_SETUP,
        ST_PULSE,
        ST_GAP,
        ST_VERIFY,
        ST_NEXT,
        ST_CK_FETCH,
        ST_CK_SET,
        ST_CK_RD,
        ST_VPP_DN,
        ST_VCC_DN,
        ST_END
    } burn_state_e;

    // Pin-level strobes decoded from the sequencer state.
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic dout_en;
        logic sig_hv;
        logic img_req;
        logic vpp;
    } strobe_t;

    localparam logic [7:0] ID_MAKER    = 8'h20;
    localparam logic [7:0] ID_PART     = 8'h8D;
    localparam int         ID_ADDR_BIT = 9;
    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    // Microseconds to clock cycles, rounded up, never below one.
    function automatic longint unsigned us_cycles(longint unsigned clk_hz,
                                                  longint unsigned us);
        longint unsigned c;
        c = (clk_hz * us + 64'd999_999) / 64'd1_000_000;
        return (c == 64'd0) ? 64'd1 : c;
    endfunction

    function automatic logic [7:0] id_byte(logic sel);
        return sel ? ID_PART : ID_MAKER;
    endfunction

    function automatic strobe_t strobes_for(burn_state_e s);
        strobe_t t;
        t = '{ce_n: 1'b1, oe_n: 1'b1, dout_en: 1'b0, sig_hv: 1'b0,
              img_req: 1'b0, vpp: 1'b0};
        case (s)
            ST_ID_SET:   t.sig_hv = 1'b1;
            ST_ID_RD: begin
                t.sig_hv = 1'b1;
                t.ce_n   = 1'b0;
                t.oe_n   = 1'b0;
            end
            ST_VPP_UP, ST_NEXT, ST_GAP, ST_CK_SET: t.vpp = 1'b1;
            ST_FETCH, ST_CK_FETCH: begin
                t.vpp     = 1'b1;
                t.img_req = 1'b1;
            end
            ST_SETUP: begin
                t.vpp     = 1'b1;
                t.dout_en = 1'b1;
            end
            ST_PULSE: begin
                t.vpp     = 1'b1;
                t.dout_en = 1'b1;
                t.ce_n    = 1'b0;
            end
            ST_VERIFY, ST_CK_RD: begin
                t.vpp  = 1'b1;
                t.oe_n = 1'b0;
            end
            default: ;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/burn_timer.sv
module burn_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/burn_addr_ctr.sv
module burn_addr_ctr #(
    parameter int AW    = 15,
    parameter int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [AW-1:0] addr,
    output logic          last
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst || clr)
            addr <= '0;
        else if (inc)
            addr <= addr + 1'b1;
    end

    assign last = (addr == LAST_ADDR);
endmodule

// File: rtl/burn_try_ctr.sv
module burn_try_ctr #(
    parameter int MAX_TRIES = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic exhausted
);
    localparam int CW = $clog2(MAX_TRIES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_TRIES);

    logic [CW-1:0] tries;

    always_ff @(posedge clk) begin
        if (rst || clr)
            tries <= '0;
        else if (inc && tries != LIMIT)
            tries <= tries + 1'b1;
    end

    assign exhausted = (tries == LIMIT);
endmodule

// File: rtl/eprom_burn_seq.sv
module eprom_burn_seq
    import eprom_burn_pkg::*;
#(
    parameter longint unsigned CLK_HZ     = 50_000_000,
    parameter int              ADDR_W     = 15,
    parameter int              DEPTH      = 1 << ADDR_W,
    parameter int              SETUP_US   = 2,
    parameter int              PULSE_US   = 100,
    parameter int              MAX_PULSES = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              id_check_en,
    output logic              img_req,
    output logic [ADDR_W-1:0] img_addr,
    input  logic              img_ack,
    input  logic [7:0]        img_data,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [7:0]        dev_dout,
    output logic              dev_dout_en,
    input  logic [7:0]        dev_din,
    output logic              dev_ce_n,
    output logic              dev_oe_n,
    output logic              vpp_en,
    output logic [1:0]        vcc_sel,
    output logic              sig_hv_en,
    output logic              done,
    output logic              fail
);
    localparam int unsigned SETUP_CYC = 32'(us_cycles(CLK_HZ, 64'(SETUP_US)));
    localparam int unsigned PULSE_CYC = 32'(us_cycles(CLK_HZ, 64'(PULSE_US)));
    localparam int          TW        = $clog2(PULSE_CYC + SETUP_CYC + 1);
    localparam logic [TW-1:0] SETUP_LD = TW'(SETUP_CYC - 1);
    localparam logic [TW-1:0] PULSE_LD = TW'(PULSE_CYC - 1);
    localparam logic [ADDR_W-1:0] ID_BASE = ADDR_W'(1) << ID_ADDR_BIT;

    burn_state_e   state_q, state_d;
    vsel_e         vsel_q, vsel_d;
    logic          id_sel_q, id_sel_d;
    logic          pass_lo_q, pass_lo_d;
    logic [7:0]    data_q, data_d;
    logic          fail_q, fail_d;

    logic          tmr_load, tmr_exp;
    logic [TW-1:0] tmr_val;
    logic          addr_clr, addr_inc, addr_last;
    logic          try_clr, try_inc, try_full;
    logic [ADDR_W-1:0] addr;
    strobe_t       st;

    burn_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
    );

    burn_addr_ctr #(.AW(ADDR_W), .DEPTH(DEPTH)) u_addr (
        .clk(clk), .rst(rst), .clr(addr_clr), .inc(addr_inc), .addr(addr), .last(addr_last)
    );

    burn_try_ctr #(.MAX_TRIES(MAX_PULSES)) u_tries (
        .clk(clk), .rst(rst), .clr(try_clr), .inc(try_inc), .exhausted(try_full)
    );

    // Sequencer next-state and control pulses.
    always_comb begin
        state_d   = state_q;
        vsel_d    = vsel_q;
        id_sel_d  = id_sel_q;
        pass_lo_d = pass_lo_q;
        data_d    = data_q;
        fail_d    = fail_q;
        tmr_load  = 1'b0;
        tmr_val   = SETUP_LD;
        addr_clr  = 1'b0;
        addr_inc  = 1'b0;
        try_clr   = 1'b0;
        try_inc   = 1'b0;

        case (state_q)
            ST_IDLE, ST_END: begin
                if (start) begin
                    fail_d    = 1'b0;
                    id_sel_d  = 1'b0;
                    pass_lo_d = 1'b0;
                    addr_clr  = 1'b1;
                    try_clr   = 1'b1;
                    tmr_load  = 1'b1;
                    if (id_check_en) begin
                        state_d = ST_ID_SET;
                    end else begin
                        state_d = ST_VCC_UP;
                        vsel_d  = VSEL_PROG;
                    end
                end
            end
            ST_ID_SET: if (tmr_exp) begin
                state_d  = ST_ID_RD;
                tmr_load = 1'b1;
            end
            ST_ID_RD: if (tmr_exp) begin
                tmr_load = 1'b1;
                if (dev_din != id_byte(id_sel_q)) begin
                    fail_d  = 1'b1;
                    state_d = ST_VPP_DN;
                end else if (!id_sel_q) begin
                    id_sel_d = 1'b1;
                    state_d  = ST_ID_SET;
                end else begin
                    vsel_d  = VSEL_PROG;
                    state_d = ST_VCC_UP;
                end
            end
            ST_VCC_UP: if (tmr_exp) begin
                state_d  = ST_VPP_UP;
                tmr_load = 1'b1;
            end
            ST_VPP_UP: if (tmr_exp) state_d = ST_FETCH;
            ST_FETCH: if (img_ack) begin
                data_d = img_data;
                if (img_data == ERASED_BYTE) begin
                    state_d = ST_NEXT;
                end else begin
                    try_clr  = 1'b1;
                    tmr_load = 1'b1;
                    state_d  = ST_SETUP;
                end
            end
            ST_SETUP: if (tmr_exp) begin
                tmr_load = 1'b1;
                tmr_val  = PULSE_LD;
                state_d  = ST_PULSE;
            end
            ST_PULSE: if (tmr_exp) begin
                try_inc  = 1'b1;
                tmr_load = 1'b1;
                state_d  = ST_GAP;
            end
            ST_GAP: if (tmr_exp) begin
                tmr_load = 1'b1;
                state_d  = ST_VERIFY;
            end
            ST_VERIFY: if (tmr_exp) begin
                if (dev_din == data_q) begin
                    state_d = ST_NEXT;
                end else if (try_full) begin
                    fail_d   = 1'b1;
                    tmr_load = 1'b1;
                    state_d  = ST_VPP_DN;
                end else begin
                    tmr_load = 1'b1;
                    state_d  = ST_SETUP;
                end
            end
            ST_NEXT: begin
                if (addr_last) begin
                    addr_clr = 1'b1;
                    vsel_d   = VSEL_HI;
                    state_d  = ST_CK_FETCH;
                end else begin
                    addr_inc = 1'b1;
                    state_d  = ST_FETCH;
                end
            end
            ST_CK_FETCH: if (img_ack) begin
                data_d   = img_data;
                tmr_load = 1'b1;
                state_d  = ST_CK_SET;
            end
            ST_CK_SET: if (tmr_exp) begin
                tmr_load = 1'b1;
                state_d  = ST_CK_RD;
            end
            ST_CK_RD: if (tmr_exp) begin
                if (dev_din != data_q) begin
                    fail_d   = 1'b1;
                    tmr_load = 1'b1;
                    state_d  = ST_VPP_DN;
                end else if (!addr_last) begin
                    addr_inc = 1'b1;
                    state_d  = ST_CK_FETCH;
                end else if (!pass_lo_q) begin
                    pass_lo_d = 1'b1;
                    vsel_d    = VSEL_LO;
                    addr_clr  = 1'b1;
                    state_d   = ST_CK_FETCH;
                end else begin
                    tmr_load = 1'b1;
                    state_d  = ST_VPP_DN;
                end
            end
            ST_VPP_DN: if (tmr_exp) begin
                vsel_d   = VSEL_NOM;
                tmr_load = 1'b1;
                state_d  = ST_VCC_DN;
            end
            ST_VCC_DN: if (tmr_exp) state_d = ST_END;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            vsel_q    <= VSEL_NOM;
            id_sel_q  <= 1'b0;
            pass_lo_q <= 1'b0;
            data_q    <= ERASED_BYTE;
            fail_q    <= 1'b0;
        end else begin
            state_q   <= state_d;
            vsel_q    <= vsel_d;
            id_sel_q  <= id_sel_d;
            pass_lo_q <= pass_lo_d;
            data_q    <= data_d;
            fail_q    <= fail_d;
        end
    end

    assign st          = strobes_for(state_q);
    assign dev_ce_n    = st.ce_n;
    assign dev_oe_n    = st.oe_n;
    assign dev_dout_en = st.dout_en;
    assign sig_hv_en   = st.sig_hv;
    assign img_req     = st.img_req;
    assign vpp_en      = st.vpp;
    assign vcc_sel     = vsel_q;
    assign img_addr    = addr;
    assign dev_addr    = st.sig_hv ? (ID_BASE | ADDR_W'(id_sel_q)) : addr;
    assign dev_dout    = data_q;
    assign done        = (state_q == ST_END);
    assign fail        = fail_q;
endmodule

// File: rtl/eprom_burn_chk.sv
module eprom_burn_chk #(
    parameter int          ADDR_W    = 15,
    parameter int unsigned PULSE_CYC = 5000
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              img_req,
    input logic              img_ack,
    input logic [ADDR_W-1:0] img_addr,
    input logic [ADDR_W-1:0] dev_addr,
    input logic              dev_dout_en,
    input logic              dev_ce_n,
    input logic              dev_oe_n,
    input logic              vpp_en,
    input logic [1:0]        vcc_sel,
    input logic              sig_hv_en,
    input logic              done,
    input logic              fail
);
    localparam int LW = $clog2(PULSE_CYC + 2);
    localparam logic [ADDR_W-1:0] ID_BASE = ADDR_W'(1) << 9;
    localparam logic [ADDR_W-1:0] A0_OFF  = ~ADDR_W'(1);

    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            low_cnt <= '0;
        else if (!dev_ce_n && vpp_en)
            low_cnt <= low_cnt + 1'b1;
        else
            low_cnt <= '0;
    end

    a_r4_pulse_width: assert property (@(posedge clk) disable iff (rst)
        (dev_ce_n && !$past(dev_ce_n) && vpp_en) |-> (low_cnt == LW'(PULSE_CYC)));

    a_r4_g_high_in_pulse: assert property (@(posedge clk) disable iff (rst)
        (!dev_ce_n && vpp_en) |-> (dev_oe_n && dev_dout_en));

    a_r5_verify_e_high: assert property (@(posedge clk) disable iff (rst)
        (!dev_oe_n && vpp_en) |-> (dev_ce_n && !dev_dout_en));

    a_r2_vpp_needs_vcc: assert property (@(posedge clk) disable iff (rst)
        vpp_en |-> (vcc_sel != 2'b00));

    a_r10_vcc_after_vpp: assert property (@(posedge clk) disable iff (rst)
        (vcc_sel == 2'b00 && $past(vcc_sel) != 2'b00) |-> (!vpp_en && !$past(vpp_en)));

    a_r9_sig_address: assert property (@(posedge clk) disable iff (rst)
        sig_hv_en |-> (!vpp_en && vcc_sel == 2'b00 && (dev_addr & A0_OFF) == ID_BASE));

    a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
        (img_req && !img_ack) |=> (img_req && img_addr == $past(img_addr)));

    a_r10_done_safe: assert property (@(posedge clk) disable iff (rst)
        done |-> (!vpp_en && vcc_sel == 2'b00 && dev_ce_n && dev_oe_n));

    a_r10_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && fail == $past(fail)));
endmodule

bind eprom_burn_seq eprom_burn_chk #(
    .ADDR_W(ADDR_W),
    .PULSE_CYC(PULSE_CYC)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .img_req(img_req), .img_ack(img_ack),
    .img_addr(img_addr), .dev_addr(dev_addr), .dev_dout_en(dev_dout_en),
    .dev_ce_n(dev_ce_n), .dev_oe_n(dev_oe_n), .vpp_en(vpp_en), .vcc_sel(vcc_sel),
    .sig_hv_en(sig_hv_en), .done(done), .fail(fail)
);

// File: tb/eprom_burn_seq_bench.sv
module eprom_burn_seq_bench;
    // Frequency parameter is scaled down (2 cycles per us) to keep runs short.
    localparam int AW      = 10;
    localparam int DEPTH   = 6;
    localparam int SETUP_C = 4;
    localparam int PULSE_C = 200;
    localparam int MAXP    = 25;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic id_check_en = 1'b0;
    logic img_req, img_ack = 1'b0;
    logic [AW-1:0] img_addr, dev_addr;
    logic [7:0] img_data = 8'h00, dev_dout, dev_din;
    logic dev_dout_en, dev_ce_n, dev_oe_n, vpp_en, sig_hv_en, done, fail;
    logic [1:0] vcc_sel;

    always #10 clk = ~clk;

    eprom_burn_seq #(.CLK_HZ(2_000_000), .ADDR_W(AW), .DEPTH(DEPTH)) u_eprom_burn_seq (
        .clk(clk), .rst(rst), .start(start), .id_check_en(id_check_en),
        .img_req(img_req), .img_addr(img_addr), .img_ack(img_ack), .img_data(img_data),
        .dev_addr(dev_addr), .dev_dout(dev_dout), .dev_dout_en(dev_dout_en),
        .dev_din(dev_din), .dev_ce_n(dev_ce_n), .dev_oe_n(dev_oe_n), .vpp_en(vpp_en),
        .vcc_sel(vcc_sel), .sig_hv_en(sig_hv_en), .done(done), .fail(fail)
    );

    // Device model and image source
    logic [7:0] mem [DEPTH];
    logic [7:0] img [DEPTH];
    int need [DEPTH];
    int pcnt [DEPTH];
    int weak_addr = -1;
    logic [7:0] id_part = 8'h8D;
    int dev_idx;

    assign dev_idx = int'(dev_addr) % DEPTH;
    always_comb begin
        if (sig_hv_en)
            dev_din = dev_addr[0] ? id_part : 8'h20;
        else if (dev_idx == weak_addr && vcc_sel == 2'b11)
            dev_din = mem[dev_idx] ^ 8'h01;
        else
            dev_din = mem[dev_idx];
    end

    typedef struct packed { logic [AW-1:0] a; logic [7:0] d; } pulse_t;
    pulse_t exp_q[$];

    int n_checks = 0, n_fail = 0;
    int n_pulses, id_reads, ver_reads, hi_reads, lo_reads, req_cnt;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Image responder: one acknowledge per request
    initial begin
        forever begin
            @(negedge clk);
            if (img_req && !img_ack && !rst) begin
                img_ack  = 1'b1;
                img_data = img[int'(img_addr) % DEPTH];
                req_cnt++;
            end else begin
                img_ack = 1'b0;
            end
        end
    end

    // Pin monitor and scoreboard
    logic p_ce = 1, p_oe = 1, p_vpp = 0, p_den = 0, g_bad = 0;
    logic [1:0] p_vcc = 0;
    logic [AW-1:0] p_addr = 0;
    logic [7:0] p_dout = 0;
    int lo = 0, stab = 0, vhold = 0, poff = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (dev_addr != p_addr || dev_dout != p_dout || dev_dout_en != p_den ||
                    vpp_en != p_vpp || vcc_sel != p_vcc) stab = 0; else stab++;
                if (vcc_sel != p_vcc) vhold = 0; else vhold++;
                if (vpp_en != p_vpp) poff = 0; else poff++;
                if (vpp_en && !p_vpp)
                    check(vcc_sel == 2'b01 && vhold >= SETUP_C, "R2", "vcc lead before vpp", vhold, SETUP_C);
                if (vcc_sel == 2'b00 && p_vcc != 2'b00)
                    check(!vpp_en && poff >= SETUP_C, "R10", "vpp off before vcc release", poff, SETUP_C);
                if (!dev_ce_n && p_ce && vpp_en)
                    check(stab >= SETUP_C, "R3", "setup before E fall", stab, SETUP_C);
                if (!dev_ce_n && vpp_en) begin
                    lo++;
                    if (!dev_oe_n || !dev_dout_en) g_bad = 1;
                end
                if (dev_ce_n && !p_ce && vpp_en) begin
                    check(lo == PULSE_C, "R4", "pulse width", lo, PULSE_C);
                    check(!g_bad, "R4", "G high and data driven in pulse", g_bad, 0);
                    if (exp_q.size() == 0) begin
                        check(0, "R6", "unexpected pulse at addr", p_addr, -1);
                    end else begin
                        pulse_t e;
                        e = exp_q.pop_front();
                        check(e.a == p_addr && e.d == p_dout, "R6", "pulse addr/data",
                              {p_addr, p_dout}, {e.a, e.d});
                    end
                    pcnt[int'(p_addr) % DEPTH]++;
                    if (pcnt[int'(p_addr) % DEPTH] >= need[int'(p_addr) % DEPTH])
                        mem[int'(p_addr) % DEPTH] = mem[int'(p_addr) % DEPTH] & p_dout;
                    n_pulses++;
                    lo = 0;
                    g_bad = 0;
                end
                if (!dev_oe_n && p_oe) begin
                    if (sig_hv_en) begin
                        check(dev_addr == (10'h200 | AW'(id_reads % 2)) && !dev_ce_n, "R9",
                              "signature read address", dev_addr, 10'h200 | AW'(id_reads % 2));
                        id_reads++;
                    end else begin
                        check(dev_ce_n && !dev_dout_en, "R5", "read with E high, bus released",
                              {dev_ce_n, dev_dout_en}, 2);
                        case (vcc_sel)
                            2'b01: ver_reads++;
                            2'b10: hi_reads++;
                            2'b11: lo_reads++;
                            default: check(0, "R8", "read at nominal supply", vcc_sel, 1);
                        endcase
                    end
                end
            end
            p_ce = dev_ce_n; p_oe = dev_oe_n; p_vpp = vpp_en; p_vcc = vcc_sel;
            p_addr = dev_addr; p_dout = dev_dout; p_den = dev_dout_en;
        end
    end

    // Driver tasks
    task automatic restart_model();
        rst = 1'b1;
        exp_q.delete();
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = 8'hFF; img[i] = 8'hFF; need[i] = 1; pcnt[i] = 0;
        end
        weak_addr = -1; id_part = 8'h8D;
        n_pulses = 0; id_reads = 0; ver_reads = 0; hi_reads = 0; lo_reads = 0; req_cnt = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_byte(input int a, input logic [7:0] d, input int n, input bit expect_pulses);
        img[a] = d;
        need[a] = n;
        if (expect_pulses && d != 8'hFF)
            for (int k = 0; k < ((n > MAXP) ? MAXP : n); k++)
                exp_q.push_back('{a: AW'(a), d: d});
    endtask

    task automatic run(input bit idc);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        id_check_en = idc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 40000; i++) begin
            if (done) break;
            @(negedge clk);
        end
        check(done, "R10", "watchdog: run did not finish", done, 1);
        check(!vpp_en && vcc_sel == 2'b00, "R10", "supplies at rest when done", {vpp_en, vcc_sel}, 0);
        check(exp_q.size() == 0, "R6", "predicted pulses left over", exp_q.size(), 0);
    endtask

    initial begin
        #4000000;
        check(0, "R10", "global watchdog expired", 0, 1);
        if (!finished) begin
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        restart_model();
        check(dev_ce_n && dev_oe_n, "R1", "strobes idle in reset", {dev_ce_n, dev_oe_n}, 3);
        @(negedge clk); rst = 1'b0; repeat (3) @(negedge clk);
        check(dev_ce_n && dev_oe_n, "R1", "strobes idle after reset", {dev_ce_n, dev_oe_n}, 3);
        check(!vpp_en && vcc_sel == 2'b00, "R1", "supplies off", {vpp_en, vcc_sel}, 0);
        check(!dev_dout_en && !sig_hv_en && !img_req, "R1", "no drive or request",
              {dev_dout_en, sig_hv_en, img_req}, 0);
        check(!done && !fail, "R1", "done/fail low", {done, fail}, 0);

        // Mixed image: skip, one, three and two pulses (R5 R6 R7 R8 R11)
        restart_model();
        set_byte(0, 8'h12, 1, 1); set_byte(1, 8'hFF, 1, 1); set_byte(2, 8'h00, 3, 1);
        set_byte(3, 8'hA5, 1, 1); set_byte(4, 8'hFF, 1, 1); set_byte(5, 8'h3C, 2, 1);
        run(1'b0);
        check(!fail, "R5", "mixed image fail flag", fail, 0);
        check(n_pulses == 7, "R6", "total pulses", n_pulses, 7);
        check(ver_reads == n_pulses, "R5", "one verify per pulse", ver_reads, n_pulses);
        check(pcnt[1] == 0 && pcnt[4] == 0, "R7", "erased bytes not pulsed", pcnt[1] + pcnt[4], 0);
        for (int i = 0; i < DEPTH; i++)
            check(mem[i] == img[i], "R5", "programmed content", mem[i], img[i]);
        check(hi_reads == DEPTH && lo_reads == DEPTH, "R8", "read-back at both levels",
              hi_reads * 100 + lo_reads, DEPTH * 101);
        check(req_cnt == 3 * DEPTH, "R11", "image requests", req_cnt, 3 * DEPTH);
        check(id_reads == 0, "R9", "no signature read when disabled", id_reads, 0);
        repeat (50) @(negedge clk);
        check(done && !fail, "R10", "done holds without start", {done, fail}, 2);

        // Signature check passes (R9)
        restart_model();
        for (int i = 0; i < DEPTH; i++) set_byte(i, 8'(i + 1), 1, 1);
        run(1'b1);
        check(id_reads == 2 && !fail, "R9", "good signature then program", id_reads * 10 + fail, 20);

        // Signature mismatch blocks programming (R9)
        restart_model();
        id_part = 8'h8C;
        for (int i = 0; i < DEPTH; i++) set_byte(i, 8'h40, 1, 0);
        run(1'b1);
        check(fail, "R9", "bad device code fails", fail, 1);
        check(n_pulses == 0 && id_reads == 2, "R9", "no pulse after bad code", n_pulses, 0);

        // Cell never programs: retry limit (R6)
        restart_model();
        set_byte(0, 8'h55, 1, 1); set_byte(1, 8'h0F, 99, 1);
        for (int i = 2; i < DEPTH; i++) set_byte(i, 8'h33, 1, 0);
        run(1'b0);
        check(fail, "R6", "retry limit fails", fail, 1);
        check(pcnt[1] == MAXP, "R6", "pulses on stuck byte", pcnt[1], MAXP);
        check(n_pulses == MAXP + 1 && hi_reads == 0, "R6", "nothing after stuck byte", n_pulses, MAXP + 1);

        // Cell weak only at lower check level (R8)
        restart_model();
        for (int i = 0; i < DEPTH; i++) set_byte(i, 8'hC3, 1, 1);
        weak_addr = 4;
        run(1'b0);
        check(fail, "R8", "low-level mismatch fails", fail, 1);
        check(hi_reads == DEPTH && lo_reads == 5, "R8", "pass order and stop point",
              hi_reads * 100 + lo_reads, DEPTH * 100 + 5);
        repeat (50) @(negedge clk);
        check(done && fail, "R10", "done and fail hold", {done, fail}, 3);

        // All-erased image (R7)
        restart_model();
        run(1'b0);
        check(n_pulses == 0 && !fail, "R7", "erased image needs no pulse", n_pulses, 0);
        check(hi_reads == DEPTH && lo_reads == DEPTH, "R8", "erased image read-back",
              hi_reads + lo_reads, 2 * DEPTH);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule